// File: doc/BRIEF.md
# Flash Write-Protection Arbiter

This block sits behind the command decoder of a serial flash device and rules on every command that could change the memory array or the status register. When chip select is released, the decoder presents one command, the 21-bit address it carried and the number of serial clocks seen during the selection. The block answers one cycle later with an accept or a reject pulse.

It owns the write-enable latch. A write-enable command sets the latch and a write-disable command clears it. Each accepted modifying command also clears the latch once its completion pulse arrives. Three tests must all pass before a command is accepted. The first is the latch itself. The second is a check that the selection lasted whole bytes. The third is a protection test that depends on the command.

The protection test works as follows. Page program and sector erase are tested against a region at the top of the array, sized by the three block-protect bits. Bulk erase needs all block-protect bits to be zero. A status write is locked out when the status-write-disable bit is set and the write-protect pin is low. The status register itself lives outside the block. On completion of an accepted status write, the block raises the register's write enable for one cycle, and that write may change only the block-protect bits and the status-write-disable bit.

Top module: `wp_arbiter`

## Requirements
- R1: While `cmdValid` is high, `cmdOp` selects the command: 0 write-enable, 1 write-disable, 2 status write, 3 page program, 4 sector erase, 5 bulk erase. In the following cycle exactly one of `acceptOut` and `rejectOut` is high, for one cycle only. Codes 6 and 7 are always rejected.
- R2: Reset (`rstN` low, asynchronous) clears `welOut`, `acceptOut`, `rejectOut` and `srWrEn`.
- R3: A write-enable command is always accepted and `welOut` reads 1 from the next cycle. The clock count and the protection settings do not affect it.
- R4: A write-disable command is always accepted and `welOut` reads 0 from the next cycle.
- R5: Codes 2 to 5 are rejected when `welOut` is 0.
- R6: Codes 2 to 5 are rejected when `sckCount` is not a multiple of 8.
- R7: A page program is rejected when its address falls in the protected region. The region is set by `bpBits` as follows:
  - 0: no region.
  - 1: 0x1F0000 and above.
  - 2: 0x1E0000 and above.
  - 3: 0x1C0000 and above.
  - 4: 0x180000 and above.
  - 5: 0x100000 and above.
  - 6 and 7: the whole array.
- R8: A sector erase is judged on the 64 KB sector holding its address (address bits [20:16]) against the same regions. It is rejected when that sector lies in the region.
- R9: A bulk erase is rejected whenever `bpBits` is nonzero.
- R10: A status write is rejected when `srwdBit` is 1 and `wpN` is 0. The write-protect pin does not affect page program.
- R11: A rejected command leaves `welOut` unchanged.
- R12: After an accepted command with code 2 to 5, `welOut` stays 1 until `doneIn`, and reads 0 in the cycle after `doneIn`. A `doneIn` with no accepted command pending has no effect.
- R13: `srWrEn` pulses for one cycle, in the cycle after `doneIn`, only when the pending accepted command is a status write. The external register then updates only the block-protect bits and the status-write-disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | One-cycle request at chip-select release |
| cmdOp | input | 3 | Command code (see R1) |
| cmdAddr | input | 21 | Target byte address |
| sckCount | input | 16 | Serial clocks counted while selected |
| doneIn | input | 1 | Completion pulse of the pending operation |
| wpN | input | 1 | Write-protect pin, low asserts the lock |
| bpBits | input | 3 | Block-protect bits from the status register |
| srwdBit | input | 1 | Status-write-disable bit from the status register |
| welOut | output | 1 | Write-enable latch |
| acceptOut | output | 1 | Accept pulse |
| rejectOut | output | 1 | Reject pulse |
| srWrEn | output | 1 | Status register write enable |

## Verification
The assertions assume that no new command arrives while an accepted modifying command is still waiting for its completion pulse. They also assume that `doneIn` never arrives in the same cycle as `cmdValid`, because the latch handling treats these as separate events. The bench keeps within both rules. After every accepted page program, erase or status write, it sends the completion pulse before the next request. It drives each command and each completion in its own cycle, with the status inputs already settled one cycle earlier.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    OP_WREN = 3'd0,
    OP_WRDI = 3'd1,
    OP_WRSR = 3'd2,
    OP_PP   = 3'd3,
    OP_SE   = 3'd4,
    OP_BE   = 3'd5
  } wpOp_e;

  // control -> datapath strobes
  typedef struct packed {
    logic welSet;
    logic welClr;
    logic accept;
    logic reject;
    logic srWrite;
  } wpStrobe_t;

  // datapath -> control check results
  typedef struct packed {
    logic byteOk;
    logic regionHit;
    logic bpAny;
    logic hwLock;
  } wpCheck_t;

endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int SECTOR_W = 16,
  parameter int BP_W     = 3,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  sckCount,
  input  logic              wpN,
  input  logic [BP_W-1:0]   bpBits,
  input  logic              srwdBit,
  input  wpStrobe_t         strb,
  output wpCheck_t          chk,
  output logic              welQ,
  output logic              acceptQ,
  output logic              rejectQ,
  output logic              srWrQ
);

  localparam int LEVELS    = 1 << BP_W;
  localparam int BYTE_BITS = 3;
  localparam logic [CNT_W-1:0] BYTE_MASK = CNT_W'((1 << BYTE_BITS) - 1);

  logic [ADDR_W-1:0] sectorBase;
  logic [ADDR_W-1:0] chkAddr;
  logic [LEVELS-1:0] levelHit;

  // sector erase is judged on the base of its sector
  assign sectorBase = {cmdAddr[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b0}}};
  assign chkAddr    = (cmdOp == OP_SE) ? sectorBase : cmdAddr;

  // one top-of-array comparator per protect level (R7, R8)
  generate
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      localparam int LOW_BIT = SECTOR_W - 1 + lv;
      if (lv == 0) begin : g_none
        assign levelHit[lv] = 1'b0;
      end else if (LOW_BIT >= ADDR_W) begin : g_all
        assign levelHit[lv] = 1'b1;
      end else begin : g_top
        assign levelHit[lv] = &chkAddr[ADDR_W-1:LOW_BIT];
      end
    end
  endgenerate

  always_comb begin
    chk.byteOk    = (sckCount & BYTE_MASK) == '0;   // R6
    chk.regionHit = levelHit[bpBits];
    chk.bpAny     = |bpBits;                         // R9
    chk.hwLock    = srwdBit & ~wpN;                  // R10
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ    <= 1'b0;
      acceptQ <= 1'b0;
      rejectQ <= 1'b0;
      srWrQ   <= 1'b0;
    end else begin
      if (strb.welSet)      welQ <= 1'b1;
      else if (strb.welClr) welQ <= 1'b0;
      acceptQ <= strb.accept;
      rejectQ <= strb.reject;
      srWrQ   <= strb.srWrite;
    end
  end

  assert_verdict_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptQ && rejectQ));

  assert_reject_keeps_wel_R11: assert property (@(posedge clk) disable iff (!rstN)
    rejectQ |-> $stable(welQ));

  assert_srwr_single_R13: assert property (@(posedge clk) disable iff (!rstN)
    srWrQ |=> !srWrQ);

endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       doneIn,
  input  wpCheck_t   chk,
  input  logic       welQ,
  output wpStrobe_t  strb
);

  logic   busy;
  logic   pendWrsr;
  logic   modifyOp;
  logic   passOk;
  wpOp_e  op;

  assign op = wpOp_e'(cmdOp);

  always_comb begin
    modifyOp = 1'b0;
    passOk   = 1'b0;
    case (op)
      OP_WRSR: begin modifyOp = 1'b1; passOk = welQ & chk.byteOk & ~chk.hwLock;    end
      OP_PP,
      OP_SE:   begin modifyOp = 1'b1; passOk = welQ & chk.byteOk & ~chk.regionHit; end
      OP_BE:   begin modifyOp = 1'b1; passOk = welQ & chk.byteOk & ~chk.bpAny;     end
      default: begin modifyOp = 1'b0; passOk = 1'b0;                               end
    endcase
  end

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      if (op == OP_WREN) begin          // R3
        strb.accept = 1'b1;
        strb.welSet = 1'b1;
      end else if (op == OP_WRDI) begin // R4
        strb.accept = 1'b1;
        strb.welClr = 1'b1;
      end else if (modifyOp) begin      // R5..R10
        strb.accept = passOk;
        strb.reject = ~passOk;
      end else begin                    // R1 unused codes
        strb.reject = 1'b1;
      end
    end else if (doneIn && busy) begin  // R12, R13
      strb.welClr  = 1'b1;
      strb.srWrite = pendWrsr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      pendWrsr <= 1'b0;
    end else if (cmdValid && modifyOp && passOk) begin
      busy     <= 1'b1;
      pendWrsr <= (op == OP_WRSR);
    end else if (doneIn && busy) begin
      busy     <= 1'b0;
      pendWrsr <= 1'b0;
    end
  end

  // input rule: no new request while an accepted operation is pending
  assert_idle_on_cmd_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmdValid);

  assert_done_clears_wel_R12: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && busy && !cmdValid) |=> !welQ);

  assert_pending_holds_wel_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneIn) |-> welQ);

  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.accept, strb.reject}));

endmodule

// File: rtl/wp_arbiter.sv
module wp_arbiter
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int SECTOR_W = 16,
  parameter int BP_W     = 3,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  sckCount,
  input  logic              doneIn,
  input  logic              wpN,
  input  logic [BP_W-1:0]   bpBits,
  input  logic              srwdBit,
  output logic              welOut,
  output logic              acceptOut,
  output logic              rejectOut,
  output logic              srWrEn
);

  wpStrobe_t strb;
  wpCheck_t  chk;
  logic      modifyReq;

  wp_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .doneIn   (doneIn),
    .chk      (chk),
    .welQ     (welOut),
    .strb     (strb)
  );

  wp_datapath #(
    .ADDR_W   (ADDR_W),
    .SECTOR_W (SECTOR_W),
    .BP_W     (BP_W),
    .CNT_W    (CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cmdOp    (cmdOp),
    .cmdAddr  (cmdAddr),
    .sckCount (sckCount),
    .wpN      (wpN),
    .bpBits   (bpBits),
    .srwdBit  (srwdBit),
    .strb     (strb),
    .chk      (chk),
    .welQ     (welOut),
    .acceptQ  (acceptOut),
    .rejectQ  (rejectOut),
    .srWrQ    (srWrEn)
  );

  assign modifyReq = cmdValid && (cmdOp == OP_WRSR || cmdOp == OP_PP ||
                                  cmdOp == OP_SE   || cmdOp == OP_BE);

  assert_verdict_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (acceptOut || rejectOut));

  assert_wel_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(welOut) |-> $past(cmdValid && cmdOp == OP_WREN));

  assert_wel_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modifyReq && !welOut) |=> rejectOut);

  assert_byte_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modifyReq && sckCount[2:0] != 3'b000) |=> rejectOut);

  assert_bulk_bp_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_BE && bpBits != '0) |=> rejectOut);

  assert_hw_lock_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_WRSR && srwdBit && !wpN) |=> rejectOut);

  assert_srwr_after_done_R13: assert property (@(posedge clk) disable iff (!rstN)
    srWrEn |-> $past(doneIn));

endmodule

// File: tb/wp_arbiter_tb.sv
module wp_arbiter_tb_top;

  localparam logic [2:0] C_WREN = 3'd0;
  localparam logic [2:0] C_WRDI = 3'd1;
  localparam logic [2:0] C_WRSR = 3'd2;
  localparam logic [2:0] C_PP   = 3'd3;
  localparam logic [2:0] C_SE   = 3'd4;
  localparam logic [2:0] C_BE   = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [20:0] addr;
    logic [15:0] cnt;
    logic [2:0]  bp;
    logic        srwd;
    logic        wp;
    logic        pre;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 35;
  localparam vec_t VECS [NVEC] = '{
    '{C_WREN, 21'h000000, 16'd8,  3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd3},
    '{C_WRDI, 21'h000000, 16'd8,  3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd4},
    '{C_PP,   21'h1FFFFF, 16'd32, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5},
    '{C_WRSR, 21'h000000, 16'd16, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5},
    '{C_BE,   21'h000000, 16'd8,  3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5},
    '{C_PP,   21'h1FFFFF, 16'd32, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
    '{C_PP,   21'h000100, 16'd33, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6},
    '{C_SE,   21'h010000, 16'd31, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6},
    '{C_WRSR, 21'h000000, 16'd12, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6},
    '{C_PP,   21'h1F0000, 16'd40, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
    '{C_PP,   21'h1EFFFF, 16'd40, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
    '{C_PP,   21'h1E0000, 16'd40, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
    '{C_PP,   21'h1DFFFF, 16'd40, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
    '{C_PP,   21'h1C0000, 16'd40, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
    '{C_PP,   21'h1BFFFF, 16'd40, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
    '{C_PP,   21'h180000, 16'd40, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
    '{C_PP,   21'h17FFFF, 16'd40, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
    '{C_PP,   21'h100000, 16'd40, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
    '{C_PP,   21'h0FFFFF, 16'd40, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7},
    '{C_PP,   21'h000000, 16'd40, 3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
    '{C_PP,   21'h000123, 16'd40, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},
    '{C_SE,   21'h1F8000, 16'd32, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd8},
    '{C_SE,   21'h1EFFFF, 16'd32, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8},
    '{C_SE,   21'h1DFFFF, 16'd32, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8},
    '{C_SE,   21'h1E4321, 16'd32, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'd8},
    '{C_SE,   21'h0ABCDE, 16'd32, 3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 8'd8},
    '{C_BE,   21'h000000, 16'd8,  3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd9},
    '{C_BE,   21'h000000, 16'd8,  3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd9},
    '{C_BE,   21'h000000, 16'd8,  3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 8'd9},
    '{C_WRSR, 21'h000000, 16'd16, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd10},
    '{C_WRSR, 21'h000000, 16'd16, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd10},
    '{C_WRSR, 21'h000000, 16'd16, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd10},
    '{C_WRSR, 21'h000000, 16'd16, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'd10},
    '{C_PP,   21'h1FFFFF, 16'd8,  3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd10},
    '{C_WREN, 21'h1FFFFF, 16'd5,  3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [20:0] cmdAddr = '0;
  logic [15:0] sckCount = '0;
  logic        doneIn = 1'b0;
  logic        wpN = 1'b1;
  logic [2:0]  bpBits = 3'd0;
  logic        srwdBit = 1'b0;
  logic        welOut, acceptOut, rejectOut, srWrEn;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;  // 50 MHz

  wp_arbiter dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .sckCount(sckCount), .doneIn(doneIn), .wpN(wpN),
    .bpBits(bpBits), .srwdBit(srwdBit), .welOut(welOut),
    .acceptOut(acceptOut), .rejectOut(rejectOut), .srWrEn(srWrEn)
  );

  task automatic check(input string tag, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [2:0] op, input logic [20:0] addr,
                         input logic [15:0] cnt);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addr; sckCount = cnt;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    doneIn = 1'b1;
    @(negedge clk);
    doneIn = 1'b0;
  endtask

  task automatic setStatus(input logic [2:0] bp, input logic srwd, input logic wp);
    @(negedge clk);
    bpBits = bp; srwdBit = srwd; wpN = wp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    check("R2 wel at reset", welOut, 0);
    check("R2 accept at reset", acceptOut, 0);
    check("R2 reject at reset", rejectOut, 0);
    check("R2 srWrEn at reset", srWrEn, 0);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      string tag;
      bit isModify;
      int welExp;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      isModify = (v.op == C_WRSR) || (v.op == C_PP) || (v.op == C_SE) || (v.op == C_BE);
      setStatus(v.bp, v.srwd, v.wp);
      if (v.pre) sendCmd(C_WREN, '0, 16'd8);
      else       sendCmd(C_WRDI, '0, 16'd8);
      sendCmd(v.op, v.addr, v.cnt);
      check({tag, " accept"}, acceptOut, v.exp);
      check({tag, " reject"}, rejectOut, !v.exp);
      if (!v.exp)                welExp = v.pre;     // R11
      else if (v.op == C_WREN)   welExp = 1;         // R3
      else if (v.op == C_WRDI)   welExp = 0;         // R4
      else                       welExp = 1;         // R12 held until done
      check({tag, " wel after verdict"}, welOut, welExp);
      @(negedge clk);
      check({tag, " R1 pulse ends"}, acceptOut | rejectOut, 0);
      if (v.exp && isModify) begin
        check({tag, " R12 wel held"}, welOut, 1);
        pulseDone();
        check({tag, " R13 srWrEn"}, srWrEn, (v.op == C_WRSR) ? 1 : 0);
        check({tag, " R12 wel cleared by done"}, welOut, 0);
        @(negedge clk);
        check({tag, " R13 srWrEn single"}, srWrEn, 0);
      end
    end

    // R1: unused codes rejected
    setStatus(3'd0, 1'b0, 1'b1);
    sendCmd(C_WREN, '0, 16'd8);
    sendCmd(3'd6, '0, 16'd8);
    check("R1 code 6 reject", rejectOut, 1);
    check("R1 code 6 accept", acceptOut, 0);
    sendCmd(3'd7, '0, 16'd8);
    check("R1 code 7 reject", rejectOut, 1);
    check("R11 wel unchanged after code 7", welOut, 1);

    // R12: stray done with nothing pending
    pulseDone();
    check("R12 stray done keeps wel", welOut, 1);
    check("R13 stray done no srWrEn", srWrEn, 0);

    // R3: repeated write-enable keeps latch set
    sendCmd(C_WREN, '0, 16'd3);
    check("R3 second wren", welOut, 1);

    // R2: mid-run reset clears latch
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R2 async reset clears wel", welOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    sendCmd(C_PP, 21'h000000, 16'd8);
    check("R5 after reset wel gate", rejectOut, 1);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule